// File: doc/BRIEF.md
# General-purpose I/O port bank with reset qualifier

This block holds the four byte-wide general-purpose port slices of a small 8-bit controller, together with the filter that turns a raw reset pin into the internal reset. Each slice keeps an output latch that the CPU writes. Each slice gives back either the latch or the pad value, and it drives the pad through three controls: a pull-down, a weak pull-up and a one-clock strong pull-up. Slice 0 is open-drain. It can also be handed to an external address/data bus, and it then drives both levels hard. Slices 1 to 3 are quasi-bidirectional, so writing a one turns a pin into an input that is held high by the weak pull-up.

Slice 3 merges alternate-function outputs from on-chip peripherals into its pins. Its pad values are also routed back to those peripherals. Slice 1 bits 0 and 1 supply the clock and the reload/capture trigger of the third timer. The raw reset pin sets the latches of slices 1 to 3 to ones at once, with no clock needed. The internal reset waits until the pin has stayed high for two machine cycles.

Top module: `gp_port_bank`

## Requirements
- R1: While `rst_pin` is high, the latches of slices 1, 2 and 3 read as 8'hFF without any clock edge. A write to those slices in that time has no effect.
- R2: `int_rst` rises on the 24th consecutive rising clock edge at which `rst_pin` is sampled high, and not before.
- R3: `int_rst` falls on the first clock edge with `rst_pin` low. A low sample restarts the count from zero.
- R4: The slice 0 latch is set to 8'hFF at a clock edge while `int_rst` is high. A write to slice 0 in that time is ignored.
- R5: With `wr_en` high, `wr_data` is stored at the clock edge into the slice that `wr_sel` names (0 to 3).
- R6: With `p0_bus_en` low, slice 0 is open-drain. `pin_pdn[0]` equals the inverted latch, and `pin_wpu[0]` and `pin_spu[0]` are zero, so a latched one floats.
- R7: With `p0_bus_en` high, slice 0 drives `p0_bus_out`. `pin_spu[0]` equals `p0_bus_out`, `pin_pdn[0]` equals its inverse, and `pin_wpu[0]` is zero.
- R8: For slices 1 to 3, the output value is the latch (for slice 3, the latch ANDed with `p3_alt_out`). `pin_wpu` equals that value and `pin_pdn` equals its inverse.
- R9: A write that changes a slice 1 to 3 latch bit from 0 to 1 raises that bit of `pin_spu` for exactly the one clock that follows the write edge. A latch set by reset gives no such pulse.
- R10: `rd_data` returns the latch of slice `rd_sel` when `rd_rmw` is high, and `pin_in` of that slice when `rd_rmw` is low.
- R11: `p3_alt_in` mirrors `pin_in[3]`. `t2_clk` is `pin_in[1][0]` and `t2_trig` is `pin_in[1][1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw reset pin, active high |
| wr_en | input | 1 | Latch write strobe |
| wr_sel | input | 2 | Slice written |
| wr_data | input | 8 | Value written |
| rd_sel | input | 2 | Slice read |
| rd_rmw | input | 1 | 1: read latch (read-modify-write), 0: read pad |
| rd_data | output | 8 | Read result |
| p0_bus_en | input | 1 | Slice 0 carries the external bus |
| p0_bus_out | input | 8 | Address/data byte driven on slice 0 |
| p3_alt_out | input | 8 | Peripheral outputs for slice 3 (1 when idle) |
| pin_in | input | 4x8 | Pad values seen per slice |
| pin_pdn | output | 4x8 | Pull-down enables |
| pin_wpu | output | 4x8 | Weak pull-up enables |
| pin_spu | output | 4x8 | Strong pull-up enables |
| p3_alt_in | output | 8 | Slice 3 pad values to peripherals |
| t2_clk | output | 1 | Third timer external clock |
| t2_trig | output | 1 | Third timer reload/capture trigger |
| int_rst | output | 1 | Qualified internal reset |

## Verification
The raw reset and a CPU write can land on the same edge. The bench raises `rst_pin` in the same cycle in which a write of 8'h00 to slice 2 is pending. The write must lose: the slice 2 latch must read 8'hFF both before and after that edge, and no strong pulse may appear on slice 2. A second overlap tests a slice 0 write made while `int_rst` is high, which must leave the latch at 8'hFF.

// File: rtl/gp_port_pkg.sv
package gp_port_pkg;
  localparam int PW     = 8;
  localparam int NPORTS = 4;
  localparam int SELW   = $clog2(NPORTS);

  // value a quasi-bidirectional pin presents: latch gated by peripheral output
  function automatic logic [PW-1:0] pin_value(input logic [PW-1:0] latch,
                                               input logic [PW-1:0] alt);
    return latch & alt;
  endfunction

  // bits that go from 0 to 1 under a write
  function automatic logic [PW-1:0] rising_bits(input logic [PW-1:0] old_v,
                                                 input logic [PW-1:0] new_v);
    return new_v & ~old_v;
  endfunction
endpackage

// File: rtl/gp_rst_qual.sv
module gp_rst_qual #(
  parameter int HOLD = 24
) (
  input  logic clk,
  input  logic rst_pin,
  output logic int_rst
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;
  logic          hit_w;   // named event: the hold window is complete

  assign hit_w = rst_pin && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_pin) begin
      cnt_q   <= '0;
      int_rst <= 1'b0;
    end else if (hit_w) begin
      int_rst <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gp_port_slice.sv
module gp_port_slice
  import gp_port_pkg::*;
#(
  parameter bit OPEN_DRAIN = 1'b0
) (
  input  logic          clk,
  input  logic          rst_pin,
  input  logic          int_rst,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_data,
  input  logic          bus_en,
  input  logic [PW-1:0] bus_out,
  input  logic [PW-1:0] alt_out,
  output logic [PW-1:0] latch_q,
  output logic [PW-1:0] pdn,
  output logic [PW-1:0] wpu,
  output logic [PW-1:0] spu
);
  logic          wr_ok_w;
  logic [PW-1:0] rise_w;     // named event: bits a write lifts from 0 to 1
  logic [PW-1:0] pulse_q;
  logic [PW-1:0] val_w;

  assign wr_ok_w = wr_en && !int_rst;
  assign rise_w  = wr_ok_w ? rising_bits(latch_q, wr_data) : '0;
  assign val_w   = pin_value(latch_q, alt_out);

  generate
    if (OPEN_DRAIN) begin : g_od_latch
      always_ff @(posedge clk) begin
        if (int_rst)      latch_q <= '1;
        else if (wr_ok_w) latch_q <= wr_data;
      end
    end else begin : g_qb_latch
      always_ff @(posedge clk or posedge rst_pin) begin
        if (rst_pin)      latch_q <= '1;
        else if (wr_ok_w) latch_q <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge rst_pin) begin
    if (rst_pin) pulse_q <= '0;
    else         pulse_q <= OPEN_DRAIN ? '0 : rise_w;
  end

  always_comb begin
    if (bus_en) begin
      spu = bus_out;
      pdn = ~bus_out;
      wpu = '0;
    end else if (OPEN_DRAIN) begin
      spu = pulse_q;
      pdn = ~val_w;
      wpu = '0;
    end else begin
      spu = pulse_q;
      pdn = ~val_w;
      wpu = val_w;
    end
  end
endmodule

// File: rtl/gp_port_bank.sv
module gp_port_bank
  import gp_port_pkg::*;
#(
  parameter int RST_HOLD = 24
) (
  input  logic                       clk,
  input  logic                       rst_pin,
  input  logic                       wr_en,
  input  logic [SELW-1:0]            wr_sel,
  input  logic [PW-1:0]              wr_data,
  input  logic [SELW-1:0]            rd_sel,
  input  logic                       rd_rmw,
  output logic [PW-1:0]              rd_data,
  input  logic                       p0_bus_en,
  input  logic [PW-1:0]              p0_bus_out,
  input  logic [PW-1:0]              p3_alt_out,
  input  logic [NPORTS-1:0][PW-1:0]  pin_in,
  output logic [NPORTS-1:0][PW-1:0]  pin_pdn,
  output logic [NPORTS-1:0][PW-1:0]  pin_wpu,
  output logic [NPORTS-1:0][PW-1:0]  pin_spu,
  output logic [PW-1:0]              p3_alt_in,
  output logic                       t2_clk,
  output logic                       t2_trig,
  output logic                       int_rst
);
  logic [NPORTS-1:0][PW-1:0] lat_w;

  gp_rst_qual #(.HOLD(RST_HOLD)) u_qual (
    .clk(clk), .rst_pin(rst_pin), .int_rst(int_rst)
  );

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_slice
      gp_port_slice #(.OPEN_DRAIN(p == 0)) u_slice (
        .clk    (clk),
        .rst_pin(rst_pin),
        .int_rst(int_rst),
        .wr_en  (wr_en && (wr_sel == SELW'(p))),
        .wr_data(wr_data),
        .bus_en ((p == 0) ? p0_bus_en : 1'b0),
        .bus_out((p == 0) ? p0_bus_out : '0),
        .alt_out((p == 3) ? p3_alt_out : '1),
        .latch_q(lat_w[p]),
        .pdn    (pin_pdn[p]),
        .wpu    (pin_wpu[p]),
        .spu    (pin_spu[p])
      );
    end
  endgenerate

  assign rd_data   = rd_rmw ? lat_w[rd_sel] : pin_in[rd_sel];
  assign p3_alt_in = pin_in[3];
  assign t2_clk    = pin_in[1][0];
  assign t2_trig   = pin_in[1][1];
endmodule

// File: rtl/gp_port_bank_chk.sv
module gp_port_bank_chk
  import gp_port_pkg::*;
#(
  parameter int RST_HOLD = 24
) (
  input logic                      clk,
  input logic                      rst_pin,
  input logic                      int_rst,
  input logic                      p0_bus_en,
  input logic [PW-1:0]             p0_bus_out,
  input logic [PW-1:0]             p3_alt_out,
  input logic [NPORTS-1:0][PW-1:0] lat_w,
  input logic [NPORTS-1:0][PW-1:0] pin_pdn,
  input logic [NPORTS-1:0][PW-1:0] pin_wpu,
  input logic [NPORTS-1:0][PW-1:0] pin_spu
);
  localparam int SW = $clog2(RST_HOLD + 1);
  logic [SW-1:0] seen_q;
  logic [3*PW-1:0] sp_w;

  always_ff @(posedge clk) begin
    if (!rst_pin)                      seen_q <= '0;
    else if (seen_q != SW'(RST_HOLD))  seen_q <= seen_q + 1'b1;
  end

  assign sp_w = {pin_spu[3], pin_spu[2], pin_spu[1]};

  assert_async_set_R1: assert property (@(negedge clk) disable iff (!rst_pin)
    1'b1 |-> (lat_w[1] == '1 && lat_w[2] == '1 && lat_w[3] == '1));

  assert_hold_len_R2: assert property (@(posedge clk) disable iff (!rst_pin)
    int_rst |-> (seen_q == SW'(RST_HOLD)));

  assert_release_R3: assert property (@(posedge clk) disable iff (rst_pin)
    !rst_pin |=> !int_rst);

  assert_p0_float_R6: assert property (@(negedge clk) disable iff (int_rst)
    !p0_bus_en |-> (pin_wpu[0] == '0 && pin_spu[0] == '0 && pin_pdn[0] == ~lat_w[0]));

  assert_p0_bus_R7: assert property (@(negedge clk) disable iff (int_rst)
    p0_bus_en |-> (pin_spu[0] == p0_bus_out && pin_wpu[0] == '0));

  assert_p3_gate_R8: assert property (@(negedge clk) disable iff (rst_pin)
    1'b1 |-> ((pin_wpu[3] & ~p3_alt_out) == '0 && (pin_wpu[3] & pin_pdn[3]) == '0));

  assert_pulse_once_R9: assert property (@(posedge clk) disable iff (rst_pin)
    (sp_w != '0) |=> ((sp_w & $past(sp_w)) == '0));
endmodule

bind gp_port_bank gp_port_bank_chk #(.RST_HOLD(RST_HOLD)) u_chk (
  .clk(clk), .rst_pin(rst_pin), .int_rst(int_rst),
  .p0_bus_en(p0_bus_en), .p0_bus_out(p0_bus_out), .p3_alt_out(p3_alt_out),
  .lat_w(lat_w), .pin_pdn(pin_pdn), .pin_wpu(pin_wpu), .pin_spu(pin_spu)
);

// File: tb/gp_port_bank_tb_top.sv
`timescale 1ns/100ps
module gp_port_bank_tb_top;
  logic clk = 1'b0;
  logic rst_pin = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic rd_rmw = 1'b1;
  logic [7:0] rd_data;
  logic p0_bus_en = 1'b0;
  logic [7:0] p0_bus_out = '0;
  logic [7:0] p3_alt_out = 8'hFF;
  logic [3:0][7:0] pin_in = '0;
  logic [3:0][7:0] pin_pdn, pin_wpu, pin_spu;
  logic [7:0] p3_alt_in;
  logic t2_clk, t2_trig, int_rst;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gp_port_bank dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic rd_latch(input logic [1:0] s, output logic [7:0] v);
    rd_sel = s; rd_rmw = 1'b1; #0.1; v = rd_data;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic t_async_set;
    #0.5 rst_pin = 1'b1;
    #1.0;
    chk("R1 p1 wpu before clock", pin_wpu[1], 8'hFF);
    chk("R1 p2 wpu before clock", pin_wpu[2], 8'hFF);
    chk("R1 p3 wpu before clock", pin_wpu[3], 8'hFF);
    tick();
    rst_pin = 1'b0;
    tick(2);
    chk("R3 int_rst low after clear", int_rst, 1'b0);
  endtask

  task automatic t_qualify;
    logic [7:0] v;
    rst_pin = 1'b1;
    tick(23);
    chk("R2 no int_rst after 23 edges", int_rst, 1'b0);
    tick();
    chk("R2 int_rst after 24 edges", int_rst, 1'b1);
    tick();
    rd_latch(2'd0, v);
    chk("R4 p0 latch set by int_rst", v, 8'hFF);
    wr(2'd0, 8'h12);
    rd_latch(2'd0, v);
    chk("R4 p0 write ignored in reset", v, 8'hFF);
    rst_pin = 1'b0;
    tick();
    chk("R3 int_rst released", int_rst, 1'b0);
    rst_pin = 1'b1; tick(10);
    rst_pin = 1'b0; tick();
    rst_pin = 1'b1; tick(23);
    chk("R3 count restarted", int_rst, 1'b0);
    rst_pin = 1'b0; tick();
  endtask

  task automatic t_write_read;
    logic [7:0] v;
    wr(2'd1, 8'hA5); wr(2'd2, 8'h3C); wr(2'd3, 8'hF0); wr(2'd0, 8'h0F);
    rd_latch(2'd1, v); chk("R5 p1 latch", v, 8'hA5);
    rd_latch(2'd2, v); chk("R5 p2 latch", v, 8'h3C);
    rd_latch(2'd3, v); chk("R5 p3 latch", v, 8'hF0);
    rd_latch(2'd0, v); chk("R5 p0 latch", v, 8'h0F);
    pin_in[2] = 8'h81; rd_sel = 2'd2; rd_rmw = 1'b0; #0.1;
    chk("R10 pad read", rd_data, 8'h81);
    rd_rmw = 1'b1; #0.1;
    chk("R10 latch read", rd_data, 8'h3C);
  endtask

  task automatic t_p0;
    wr(2'd0, 8'hC3);
    chk("R6 p0 pdn", pin_pdn[0], 8'h3C);
    chk("R6 p0 wpu", pin_wpu[0], 8'h00);
    chk("R6 p0 spu", pin_spu[0], 8'h00);
    p0_bus_en = 1'b1; p0_bus_out = 8'h5A; #0.1;
    chk("R7 bus spu", pin_spu[0], 8'h5A);
    chk("R7 bus pdn", pin_pdn[0], 8'hA5);
    chk("R7 bus wpu", pin_wpu[0], 8'h00);
    p0_bus_en = 1'b0;
  endtask

  task automatic t_drive;
    wr(2'd2, 8'h96);
    chk("R8 p2 wpu", pin_wpu[2], 8'h96);
    chk("R8 p2 pdn", pin_pdn[2], 8'h69);
    wr(2'd3, 8'hFF);
    tick();
    p3_alt_out = 8'b1111_1101; #0.1;
    chk("R8 p3 alt gates wpu", pin_wpu[3], 8'hFD);
    chk("R8 p3 alt gates pdn", pin_pdn[3], 8'h02);
    p3_alt_out = 8'hFF;
  endtask

  task automatic t_pulse;
    wr(2'd1, 8'h00);
    tick();
    wr(2'd1, 8'h21);
    chk("R9 pulse after write edge", pin_spu[1], 8'h21);
    tick();
    chk("R9 pulse lasts one clock", pin_spu[1], 8'h00);
    wr(2'd1, 8'h21);
    chk("R9 no pulse for unchanged bits", pin_spu[1], 8'h00);
  endtask

  task automatic t_alt_in;
    pin_in[3] = 8'h4B; pin_in[1] = 8'b0000_0010; #0.1;
    chk("R11 p3 alt in", p3_alt_in, 8'h4B);
    chk("R11 t2 clk", t2_clk, 1'b0);
    chk("R11 t2 trig", t2_trig, 1'b1);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    wr(2'd2, 8'h00);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h00;
    rst_pin = 1'b1; #0.1;
    rd_latch(2'd2, v);
    chk("R1 async set before edge", v, 8'hFF);
    tick();
    wr_en = 1'b0;
    rd_latch(2'd2, v);
    chk("R1 write loses to reset", v, 8'hFF);
    chk("R9 no pulse from reset", pin_spu[2], 8'h00);
    rst_pin = 1'b0; tick();
  endtask

  initial begin
    fork
      begin
        t_async_set();
        t_qualify();
        t_write_read();
        t_p0();
        t_drive();
        t_pulse();
        t_alt_in();
        t_collide();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule